// File: doc/BRIEF.md
# Overlap-Safe Blit Setup Unit

This block sits in front of a 2D rectangle-copy engine and turns one copy request into the start-up command that engine needs. A request carries a source corner, a destination corner, a width, a height and a flag for packed 24-bit pixels. The block picks the horizontal and vertical traversal directions so that a copy between overlapping rectangles never reads a pixel it has already overwritten. It moves both corners to the side the traversal starts from and packs the corners and the size into 32-bit words.

In 24-bit mode the engine works on bytes, so every horizontal quantity is tripled first. The block then derives a 3-bit byte-rotation code, a residue modulo 6 that tells the engine where a pixel starts within its 4-byte word. Requests arrive over a valid/ready handshake. Each accepted request yields either one command beat, one error beat, or nothing when the rectangle is empty.

Top module: `blit_setup_unit`

## Requirements
- R1: After reset `req_ready` is 1 and `cmd_valid` and `cmd_err` are 0. A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for the following cycle. The resulting `cmd_valid` or `cmd_err` pulse is high for exactly the one cycle after the second rising edge following acceptance.
- R2: A request with width 0 or height 0 yields neither `cmd_valid` nor `cmd_err`.
- R3: When `req_mode24` is 1, source x, destination x and width are multiplied by 3 before any other step. The width field of `cmd_size` carries the tripled width.
- R4: If source y < destination y, both y values are increased by height−1 and control bit 1 (top-to-bottom) is 0. Otherwise the y values are unchanged and bit 1 is 1.
- R5: If the scaled source x < the scaled destination x, both x values are increased by scaled width−1 and control bit 0 (left-to-right) is 0. Otherwise the x values are unchanged and bit 0 is 1.
- R6: In 24-bit mode, control bits 10:8 hold (dx/4) mod 6 for left-to-right traversal and ((dx+2)/4) mod 6 for right-to-left, where dx is the adjusted destination x. Outside 24-bit mode these bits are 0.
- R7: Control bit 2 (draw last pixel) is always 1. Bit 7 (rotation enable) equals `req_mode24`. All other control bits are 0.
- R8: `cmd_src_xy` and `cmd_dst_xy` hold x in bits 31:16 and y in bits 15:0. `cmd_size` holds width in bits 31:16 and height in bits 15:0.
- R9: A non-empty request raises `cmd_err` instead of `cmd_valid` if any of the following exceeds 65535: the scaled source x, the scaled destination x, the scaled width, or any adjusted corner coordinate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_sx | input | 16 | Source x in pixels |
| req_sy | input | 16 | Source y |
| req_dx | input | 16 | Destination x in pixels |
| req_dy | input | 16 | Destination y |
| req_w | input | 16 | Width in pixels |
| req_h | input | 16 | Height in lines |
| req_mode24 | input | 1 | Packed 24-bit pixel mode |
| cmd_valid | output | 1 | One-cycle command beat |
| cmd_err | output | 1 | One-cycle overflow error beat |
| cmd_src_xy | output | 32 | Start source corner, x high / y low |
| cmd_dst_xy | output | 32 | Start destination corner, x high / y low |
| cmd_size | output | 32 | Width high / height low |
| cmd_ctrl | output | 16 | Direction, last-pixel and rotation control |

## Verification
The sweep covers every ordering of source and destination in both axes, including equal coordinates. A design that used less-or-equal instead of strict less-than would flip the direction there and start from the wrong corner. Widths of zero and heights of zero are mixed into the sweep; a block that let them through would emit a degenerate command. Destination x runs across several multiples of 4 in 24-bit mode in both traversal directions. An off-by-two in the rotation offset, or a residue taken modulo 4 instead of 6, therefore shows up as a wrong code. Values just at and just past 65535 after tripling and after corner adjustment separate a correct overflow test from one that truncates silently.

// File: rtl/blit_setup_pkg.sv
// Shared constants for the blit setup unit: bit positions inside the
// control word handed to the copy engine. Assumes a 16-bit control word.
package blit_setup_pkg;
    localparam int CTRL_W   = 16;
    localparam int CB_XL2R  = 0;   // horizontal traversal left-to-right
    localparam int CB_YT2B  = 1;   // vertical traversal top-to-bottom
    localparam int CB_LAST  = 2;   // draw the final pixel
    localparam int CB_ROTEN = 7;   // byte-rotation enable
    localparam int CB_ROT   = 8;   // rotation code, lowest bit
    localparam int ROT_W    = 3;   // rotation code width (values 0..5)
endpackage

// File: rtl/blit_mod6.sv
// Constant-divisor residue: res = val mod 6, purely combinational.
// Mod 3 is folded over 2-bit digits (4 = 1 mod 3); parity picks r or r+3.
// Assumes IW >= 2.
module blit_mod6 #(
    parameter int IW = 17
) (
    input  logic [IW-1:0] val,
    output logic [2:0]    res
);
    localparam int NP = (IW + 1) / 2;

    logic [2*NP-1:0] padded;
    logic [1:0]      r3;

    // Fold base-4 digits into a running mod-3 residue
    always_comb begin
        logic [2:0] acc;
        padded = (2*NP)'(val);
        r3     = 2'd0;
        for (int i = 0; i < NP; i++) begin
            acc = {1'b0, r3} + {1'b0, padded[2*i +: 2]};
            if (acc >= 3'd3) acc = acc - 3'd3;
            r3 = acc[1:0];
        end
    end

    // Combine mod-3 and mod-2 residues into mod 6
    always_comb begin
        if (r3[0] == val[0]) res = {1'b0, r3};
        else                 res = {1'b0, r3} + 3'd3;
    end
endmodule

// File: rtl/blit_scale_stage.sv
// First pipeline stage: captures an accepted request, triples the
// horizontal quantities in 24-bit mode and flags empty rectangles.
// Assumes 'acc' is only high when the stage is free.
module blit_scale_stage #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic [CW-1:0] sx,
    input  logic [CW-1:0] sy,
    input  logic [CW-1:0] dx,
    input  logic [CW-1:0] dy,
    input  logic [CW-1:0] w,
    input  logic [CW-1:0] h,
    input  logic          mode24,
    output logic          s1_valid,
    output logic          s1_zero,
    output logic          s1_mode24,
    output logic [CW+1:0] s1_sx,
    output logic [CW+1:0] s1_dx,
    output logic [CW+1:0] s1_w,
    output logic [CW-1:0] s1_sy,
    output logic [CW-1:0] s1_dy,
    output logic [CW-1:0] s1_h
);
    localparam int SW = CW + 2;

    // Times-three as shift-and-add, chosen by mode
    function automatic logic [SW-1:0] scale(input logic [CW-1:0] v, input logic m);
        logic [SW-1:0] ext;
        ext = SW'(v);
        return m ? (ext + {ext[SW-2:0], 1'b0}) : ext;
    endfunction

    // Occupancy flag of the stage
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= acc;
    end

    // Capture and scale the request fields on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_zero   <= 1'b0;
            s1_mode24 <= 1'b0;
            s1_sx     <= '0;
            s1_dx     <= '0;
            s1_w      <= '0;
            s1_sy     <= '0;
            s1_dy     <= '0;
            s1_h      <= '0;
        end else if (acc) begin
            s1_zero   <= (w == '0) || (h == '0);
            s1_mode24 <= mode24;
            s1_sx     <= scale(sx, mode24);
            s1_dx     <= scale(dx, mode24);
            s1_w      <= scale(w, mode24);
            s1_sy     <= sy;
            s1_dy     <= dy;
            s1_h      <= h;
        end
    end
endmodule

// File: rtl/blit_orient_stage.sv
// Second pipeline stage: chooses traversal directions from overlap,
// moves corners, derives the 24-bit rotation code, checks range and
// registers the command or error beat.
// Assumes stage-1 fields are stable while s1_valid is high.
module blit_orient_stage
    import blit_setup_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  logic              s1_zero,
    input  logic              s1_mode24,
    input  logic [CW+1:0]     s1_sx,
    input  logic [CW+1:0]     s1_dx,
    input  logic [CW+1:0]     s1_w,
    input  logic [CW-1:0]     s1_sy,
    input  logic [CW-1:0]     s1_dy,
    input  logic [CW-1:0]     s1_h,
    output logic              cmd_valid,
    output logic              cmd_err,
    output logic [2*CW-1:0]   cmd_src_xy,
    output logic [2*CW-1:0]   cmd_dst_xy,
    output logic [2*CW-1:0]   cmd_size,
    output logic [CTRL_W-1:0] cmd_ctrl
);
    localparam int SW = CW + 2;
    localparam int XW = CW + 3;
    localparam int YW = CW + 1;

    logic          x_rl, y_up;
    logic [XW-1:0] sx_c, dx_c, rot_base;
    logic [YW-1:0] sy_c, dy_c;
    logic [2:0]    rot;
    logic          ovf;
    logic [CTRL_W-1:0] ctrl_n;

    // Vertical direction and y corners
    always_comb begin
        y_up = s1_sy < s1_dy;
        sy_c = y_up ? (YW'(s1_sy) + YW'(s1_h) - YW'(1)) : YW'(s1_sy);
        dy_c = y_up ? (YW'(s1_dy) + YW'(s1_h) - YW'(1)) : YW'(s1_dy);
    end

    // Horizontal direction and x corners on scaled values
    always_comb begin
        x_rl = s1_sx < s1_dx;
        sx_c = x_rl ? (XW'(s1_sx) + XW'(s1_w) - XW'(1)) : XW'(s1_sx);
        dx_c = x_rl ? (XW'(s1_dx) + XW'(s1_w) - XW'(1)) : XW'(s1_dx);
        rot_base = x_rl ? (dx_c + XW'(2)) : dx_c;
    end

    blit_mod6 #(.IW(XW-2)) u_mod6 (
        .val (rot_base[XW-1:2]),
        .res (rot)
    );

    // Range check: any bit above the coordinate width is an overflow
    always_comb begin
        ovf = (|s1_sx[SW-1:CW]) | (|s1_dx[SW-1:CW]) | (|s1_w[SW-1:CW])
            | (|sx_c[XW-1:CW])  | (|dx_c[XW-1:CW])
            | sy_c[CW]          | dy_c[CW];
    end

    // Assemble the control word
    always_comb begin
        ctrl_n = '0;
        ctrl_n[CB_XL2R]  = ~x_rl;
        ctrl_n[CB_YT2B]  = ~y_up;
        ctrl_n[CB_LAST]  = 1'b1;
        ctrl_n[CB_ROTEN] = s1_mode24;
        ctrl_n[CB_ROT +: ROT_W] = s1_mode24 ? rot : '0;
    end

    // One-cycle beat flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_err   <= 1'b0;
        end else begin
            cmd_valid <= s1_valid & ~s1_zero & ~ovf;
            cmd_err   <= s1_valid & ~s1_zero & ovf;
        end
    end

    // Command payload, loaded with each stage-1 result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_src_xy <= '0;
            cmd_dst_xy <= '0;
            cmd_size   <= '0;
            cmd_ctrl   <= '0;
        end else if (s1_valid) begin
            cmd_src_xy <= {sx_c[CW-1:0], sy_c[CW-1:0]};
            cmd_dst_xy <= {dx_c[CW-1:0], dy_c[CW-1:0]};
            cmd_size   <= {s1_w[CW-1:0], s1_h};
            cmd_ctrl   <= ctrl_n;
        end
    end
endmodule

// File: rtl/blit_setup_unit.sv
// Top of the blit setup unit. Two-stage pipeline: scale, then orient and
// pack. Takes one request every other cycle; ready is low while a
// request sits in the first stage. No backpressure on the command side.
module blit_setup_unit
    import blit_setup_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CW-1:0]     req_sx,
    input  logic [CW-1:0]     req_sy,
    input  logic [CW-1:0]     req_dx,
    input  logic [CW-1:0]     req_dy,
    input  logic [CW-1:0]     req_w,
    input  logic [CW-1:0]     req_h,
    input  logic              req_mode24,
    output logic              cmd_valid,
    output logic              cmd_err,
    output logic [2*CW-1:0]   cmd_src_xy,
    output logic [2*CW-1:0]   cmd_dst_xy,
    output logic [2*CW-1:0]   cmd_size,
    output logic [CTRL_W-1:0] cmd_ctrl
);
    logic          acc;
    logic          s1_valid, s1_zero, s1_mode24;
    logic [CW+1:0] s1_sx, s1_dx, s1_w;
    logic [CW-1:0] s1_sy, s1_dy, s1_h;

    // Handshake: free whenever the first stage is empty
    always_comb begin
        req_ready = ~s1_valid;
        acc       = req_valid & req_ready;
    end

    blit_scale_stage #(.CW(CW)) u_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .sx        (req_sx),
        .sy        (req_sy),
        .dx        (req_dx),
        .dy        (req_dy),
        .w         (req_w),
        .h         (req_h),
        .mode24    (req_mode24),
        .s1_valid  (s1_valid),
        .s1_zero   (s1_zero),
        .s1_mode24 (s1_mode24),
        .s1_sx     (s1_sx),
        .s1_dx     (s1_dx),
        .s1_w      (s1_w),
        .s1_sy     (s1_sy),
        .s1_dy     (s1_dy),
        .s1_h      (s1_h)
    );

    blit_orient_stage #(.CW(CW)) u_orient (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_valid   (s1_valid),
        .s1_zero    (s1_zero),
        .s1_mode24  (s1_mode24),
        .s1_sx      (s1_sx),
        .s1_dx      (s1_dx),
        .s1_w       (s1_w),
        .s1_sy      (s1_sy),
        .s1_dy      (s1_dy),
        .s1_h       (s1_h),
        .cmd_valid  (cmd_valid),
        .cmd_err    (cmd_err),
        .cmd_src_xy (cmd_src_xy),
        .cmd_dst_xy (cmd_dst_xy),
        .cmd_size   (cmd_size),
        .cmd_ctrl   (cmd_ctrl)
    );
endmodule

// File: rtl/blit_setup_unit_chk.sv
// Property checker for blit_setup_unit, attached by bind below.
// Observes the handshake and the command port only.
module blit_setup_unit_chk
    import blit_setup_pkg::*;
#(
    parameter int CW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [CW-1:0]     req_w,
    input logic [CW-1:0]     req_h,
    input logic              cmd_valid,
    input logic              cmd_err,
    input logic [CTRL_W-1:0] cmd_ctrl
);
    assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_single_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || cmd_err) |=> !(cmd_valid || cmd_err));

    assert_result_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_w != '0 && req_h != '0) |=> ##1 (cmd_valid || cmd_err));

    assert_empty_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_w == '0 || req_h == '0)) |=> ##1 (!cmd_valid && !cmd_err));

    assert_rot_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_ctrl[CB_ROT +: ROT_W] < 3'd6));

    assert_rot_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ctrl[CB_ROTEN]) |-> (cmd_ctrl[CB_ROT +: ROT_W] == '0));

    assert_last_pel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_ctrl[CB_LAST]);

    assert_no_overlap_beats_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_err));
endmodule

bind blit_setup_unit blit_setup_unit_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_w     (req_w),
    .req_h     (req_h),
    .cmd_valid (cmd_valid),
    .cmd_err   (cmd_err),
    .cmd_ctrl  (cmd_ctrl)
);

// File: tb/blit_setup_unit_test.sv
// Sweep bench for blit_setup_unit with an arithmetic reference model.
module blit_setup_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_sx = '0, req_sy = '0, req_dx = '0, req_dy = '0, req_w = '0, req_h = '0;
    logic        req_mode24 = 1'b0;
    logic        cmd_valid, cmd_err;
    logic [31:0] cmd_src_xy, cmd_dst_xy, cmd_size;
    logic [15:0] cmd_ctrl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    blit_setup_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_sx     (req_sx),
        .req_sy     (req_sy),
        .req_dx     (req_dx),
        .req_dy     (req_dy),
        .req_w      (req_w),
        .req_h      (req_h),
        .req_mode24 (req_mode24),
        .cmd_valid  (cmd_valid),
        .cmd_err    (cmd_err),
        .cmd_src_xy (cmd_src_xy),
        .cmd_dst_xy (cmd_dst_xy),
        .cmd_size   (cmd_size),
        .cmd_ctrl   (cmd_ctrl)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Send one request and compare the resulting beat with the model
    task automatic run(input int m, input int sx, input int sy, input int dx,
                       input int dy, input int w, input int h);
        int sxs, dxs, ws, sxc, dxc, syc, dyc, rot, ctrl;
        bit xrl, yup, zero, ovf;
        sxs = m ? sx*3 : sx;
        dxs = m ? dx*3 : dx;
        ws  = m ? w*3  : w;
        zero = (w == 0) || (h == 0);
        yup = sy < dy;
        syc = yup ? sy + h - 1 : sy;
        dyc = yup ? dy + h - 1 : dy;
        xrl = sxs < dxs;
        sxc = xrl ? sxs + ws - 1 : sxs;
        dxc = xrl ? dxs + ws - 1 : dxs;
        rot = m ? (((xrl ? dxc + 2 : dxc) / 4) % 6) : 0;
        ovf = (sxs > 65535) || (dxs > 65535) || (ws > 65535) || (sxc > 65535)
           || (dxc > 65535) || (syc > 65535) || (dyc > 65535);
        ctrl = (xrl ? 0 : 1) | ((yup ? 0 : 1) << 1) | 4 | (m << 7) | (rot << 8);

        @(negedge clk);
        chk("R1 beat single cycle", {cmd_valid, cmd_err}, 0);
        chk("R1 ready idle", req_ready, 1);
        req_sx = 16'(sx); req_sy = 16'(sy); req_dx = 16'(dx); req_dy = 16'(dy);
        req_w = 16'(w); req_h = 16'(h); req_mode24 = m[0];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 ready low pending", req_ready, 0);
        chk("R1 no early beat", {cmd_valid, cmd_err}, 0);
        @(negedge clk);
        if (zero) begin
            chk("R2 empty no cmd", cmd_valid, 0);
            chk("R2 empty no err", cmd_err, 0);
        end else if (ovf) begin
            chk("R9 overflow err", cmd_err, 1);
            chk("R9 overflow no cmd", cmd_valid, 0);
        end else begin
            chk("R1 cmd beat", cmd_valid, 1);
            chk("R9 no false err", cmd_err, 0);
            chk("R5 x direction", cmd_ctrl[0], xrl ? 0 : 1);
            chk("R4 y direction", cmd_ctrl[1], yup ? 0 : 1);
            chk("R6 rotation", cmd_ctrl[10:8], rot);
            chk("R7 control word", cmd_ctrl, ctrl);
            chk("R8 src corner", cmd_src_xy, (longint'(sxc) << 16) | syc);
            chk("R8 dst corner", cmd_dst_xy, (longint'(dxc) << 16) | dyc);
            chk("R3 size word", cmd_size, (longint'(ws) << 16) | h);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ready", req_ready, 1);
        chk("R1 reset cmd_valid", cmd_valid, 0);
        chk("R1 reset cmd_err", cmd_err, 0);
        rst_n = 1'b1;

        // Near-exhaustive small sweep: orderings, empties, both modes
        for (int m = 0; m < 2; m++)
            for (int sx = 0; sx < 6; sx++)
                for (int dx = 0; dx < 6; dx++)
                    for (int sy = 0; sy < 3; sy++)
                        for (int dy = 0; dy < 3; dy++)
                            for (int w = 0; w < 4; w++)
                                for (int h = 0; h < 3; h++)
                                    run(m, sx, sy, dx, dy, w, h);

        // Rotation sweep across many multiples of 4, both directions (R6)
        for (int dx = 0; dx < 64; dx++)
            for (int w = 1; w < 4; w++) begin
                run(1, 0, 5, dx, 5, w, 2);
                run(1, 300, 5, dx, 5, w, 2);
            end

        // Range edges (R9, R3)
        run(1, 21845, 0, 0, 0, 1, 1);     // 65535 exactly: accepted
        run(1, 21846, 0, 0, 0, 1, 1);     // scaled sx 65538: error
        run(1, 0, 0, 21846, 0, 1, 1);     // scaled dx overflow
        run(1, 0, 0, 0, 0, 21846, 1);     // scaled width overflow
        run(0, 65520, 0, 65535, 0, 1, 1); // right-to-left corner at limit
        run(0, 65520, 0, 65535, 0, 2, 1); // corner one past limit
        run(0, 0, 10, 0, 65535, 1, 2);    // bottom-to-top y overflow
        run(0, 0, 10, 0, 65535, 1, 1);    // y corner at limit
        run(0, 65535, 65535, 0, 0, 65535, 65535); // left-to-right, no advance

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: ends a hung run as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule